// File: doc/BRIEF.md
# Multi-CPU Device Interrupt Router

The router gathers up to 64 level-sensitive device interrupt lines into one raw request vector. Each of up to four CPUs has its own 64-bit enable mask. A CPU's hard-interrupt output is high whenever any raw request bit that its mask enables is high. A separate cascade input, fed by a legacy interrupt controller, shares raw bit 55 with device line 55.

Software reaches the router through a 32-bit register port and works on 64-bit values in two halves:

- **Writes.** A write to a low half only parks the word in a holding latch. The following write to the high half combines the new high word with the held low word and commits the 64-bit result.
- **Reads.** A read of a low half returns the low word and parks the high word in the same latch. A read of a high half returns whatever the latch holds.

Software can read the raw vector, each mask, and each CPU's masked request. The masked request is computed on every read and is not stored. Only the masks can be written.

Top module: `irq_router_top`

## Requirements
- R1: After reset every mask and the raw vector are zero, every `cpu_irq` bit is low, and `bus_rdata` and `bus_err` are zero.
- R2: Raw bit i takes the level of `dev_irq[i]` at each rising clock edge (one register stage by default). The raw vector is readable at offset 0x300 (low word) and 0x304 (high word).
- R3: Raw bit 55 is the OR of `cascade_irq` and `dev_irq[55]`.
- R4: The masked request of CPU n reads as mask n AND raw vector. Masked requests sit at 0x280, 0x2C0, 0x680 and 0x6C0 for CPUs 0 to 3.
- R5: `cpu_irq[n]` is high exactly when mask n AND raw is non-zero. It is evaluated from the register values, so it changes right after the clock edge that updates the raw vector or mask n.
- R6: Masks sit at 0x200, 0x240, 0x600 and 0x640 for CPUs 0 to 3.
  - A write with address bit 2 clear only loads `bus_wdata` into the holding latch.
  - A write with bit 2 set stores {`bus_wdata`, latch} into the mask at that offset with bit 2 cleared.
  - When `bus_wr` and `bus_rd` are both high, the write is performed and the read is dropped.
- R7: High-half writes to the raw or masked-request offsets change no register and raise no error.
- R8: A read with bit 2 clear sets `bus_rdata` to the low word at the next edge and loads the high word into the latch. A read with bit 2 set returns the latch.
- R9: An offset outside the map pulses `bus_err` for one cycle on a low-half read or a high-half write. A low-half read of such an offset returns 0xFFFFFFFF and leaves the latch unchanged. A high-half read of any offset returns the latch without error.
- R10: Reads and writes share one latch. A low-half write placed between a low-half read and its high-half read replaces the word that the high-half read returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_irq | input | 64 | Device interrupt levels |
| cascade_irq | input | 1 | Legacy controller level, merged into raw bit 55 |
| bus_addr | input | 12 | Byte offset of the 32-bit access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write word |
| bus_rdata | output | 32 | Read word, registered, held until the next read |
| bus_err | output | 1 | One-cycle unassigned-access pulse |
| cpu_irq | output | 4 | Per-CPU hard-interrupt level |

## Verification
Two things can land on the same clock edge: a device line changing the raw vector, and a register access that commits a mask or reads a masked request.

The bench drives random line levels together with random accesses, including both strobes at once. The two therefore collide often:
- a mask commit on the edge where the raw vector changes;
- a masked-request read on the edge where its raw bits move.

A behavioural model applies each edge's access to the pre-edge register values and the new raw vector afterwards. It is compared with `cpu_irq`, `bus_rdata` and `bus_err` on every cycle. In particular, a masked-request read must return the pre-edge AND, while `cpu_irq` must already reflect both updates.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_MASK = 2'd1,
      SEL_MREQ = 2'd2,
      SEL_RAW  = 2'd3
   } reg_sel_e;

   localparam int unsigned MAX_CPUS    = 4;
   localparam int unsigned MAP_BITS    = 12;
   localparam logic [11:0] RAW_OFFSET  = 12'h300;
   localparam logic [11:0] MREQ_DELTA  = 12'h080;
   localparam logic [11:0] LOW_BANK    = 12'h200;
   localparam logic [11:0] HIGH_BANK   = 12'h600;
   localparam logic [11:0] CPU_STRIDE  = 12'h040;

   // CPUs 0/1 live in the low bank, CPUs 2/3 in the high bank.
   function automatic logic [11:0] mask_offset(input int unsigned cpu);
      logic [11:0] off;
      off = (cpu < 2) ? LOW_BANK : HIGH_BANK;
      if ((cpu % 2) != 0) off = off + CPU_STRIDE;
      return off;
   endfunction

endpackage

// File: rtl/irq_raw_capture.sv
module irq_raw_capture #(
   parameter int NUM_LINES   = 64,
   parameter int REG_W       = 64,
   parameter int CASCADE_BIT = 55,
   parameter int SYNC_STAGES = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] dev_irq,
   input  logic                 cascade_irq,
   output logic [REG_W-1:0]     raw_q
);

   if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must lie in 1..4");
   end
   if (CASCADE_BIT < 0 || CASCADE_BIT >= NUM_LINES) begin : g_bad_casc
      $error("CASCADE_BIT must address an existing line");
   end

   logic [REG_W-1:0] line_lvl;

   for (genvar i = 0; i < REG_W; i++) begin : g_line
      if (i == CASCADE_BIT) begin : g_shared
         assign line_lvl[i] = dev_irq[i] | cascade_irq;
      end else if (i < NUM_LINES) begin : g_dev
         assign line_lvl[i] = dev_irq[i];
      end else begin : g_tie
         assign line_lvl[i] = 1'b0;
      end
   end

   if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
         if (!rst_n) raw_q <= '0;
         else        raw_q <= line_lvl;
      end

      AST_CASCADE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
         cascade_irq |=> raw_q[CASCADE_BIT]); // R3
      AST_RAW_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
         (!cascade_irq && !dev_irq[0]) |=> !raw_q[0]); // R2
   end else begin : g_chain
      logic [SYNC_STAGES-1:0][REG_W-1:0] stage_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            stage_q <= '0;
         end else begin
            stage_q[0] <= line_lvl;
            for (int s = 1; s < SYNC_STAGES; s++) stage_q[s] <= stage_q[s-1];
         end
      end
      assign raw_q = stage_q[SYNC_STAGES-1];
   end

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
   parameter int NUM_CPUS = 4,
   parameter int REG_W    = 64
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [NUM_CPUS-1:0]                wr_en,
   input  logic [REG_W-1:0]                   wr_val,
   input  logic [REG_W-1:0]                   raw_q,
   output logic [NUM_CPUS-1:0][REG_W-1:0]     mask_q,
   output logic [NUM_CPUS-1:0]                cpu_irq
);

   for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
      always_ff @(posedge clk) begin
         if (!rst_n)        mask_q[c] <= '0;
         else if (wr_en[c]) mask_q[c] <= wr_val;
      end

      assign cpu_irq[c] = |(mask_q[c] & raw_q);

      AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
         !wr_en[c] |=> $stable(mask_q[c])); // R7
      AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
         (mask_q[c] == '0) |-> !cpu_irq[c]); // R5
      AST_IRQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
         (raw_q == '0) |-> !cpu_irq[c]); // R5
   end

endmodule

// File: rtl/irq_csr_port.sv
module irq_csr_port
   import irq_router_pkg::*;
#(
   parameter int NUM_CPUS = 4,
   parameter int DATA_W   = 32,
   parameter int REG_W    = 64,
   parameter int ADDR_W   = 12
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [ADDR_W-1:0]              bus_addr,
   input  logic                           bus_wr,
   input  logic                           bus_rd,
   input  logic [DATA_W-1:0]              bus_wdata,
   output logic [DATA_W-1:0]              bus_rdata,
   output logic                           bus_err,
   input  logic [REG_W-1:0]               raw_q,
   input  logic [NUM_CPUS-1:0][REG_W-1:0] mask_q,
   output logic [NUM_CPUS-1:0]            mask_wr_en,
   output logic [REG_W-1:0]               mask_wr_val
);

   localparam int CPU_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1;
   localparam logic [ADDR_W-1:0] HALF_BIT = ADDR_W'(4);

   if (REG_W != 2 * DATA_W) begin : g_bad_w
      $error("REG_W must be twice DATA_W");
   end
   if (ADDR_W < MAP_BITS) begin : g_bad_a
      $error("ADDR_W too narrow for the register map");
   end

   logic [ADDR_W-1:0] base_addr;
   logic              hi_half;
   reg_sel_e          hit_sel;
   logic [CPU_W-1:0]  hit_cpu;
   logic [REG_W-1:0]  read_val;
   logic [DATA_W-1:0] latch_q;
   logic [DATA_W-1:0] rdata_q;
   logic              err_q;

   assign base_addr = bus_addr & ~HALF_BIT;
   assign hi_half   = bus_addr[2];

   always_comb begin
      hit_sel = SEL_NONE;
      hit_cpu = '0;
      if (base_addr == ADDR_W'(RAW_OFFSET)) hit_sel = SEL_RAW;
      for (int c = 0; c < NUM_CPUS; c++) begin
         if (base_addr == ADDR_W'(mask_offset(c))) begin
            hit_sel = SEL_MASK;
            hit_cpu = CPU_W'(c);
         end
         if (base_addr == ADDR_W'(mask_offset(c) + MREQ_DELTA)) begin
            hit_sel = SEL_MREQ;
            hit_cpu = CPU_W'(c);
         end
      end
   end

   always_comb begin
      case (hit_sel)
         SEL_RAW:  read_val = raw_q;
         SEL_MASK: read_val = mask_q[hit_cpu];
         SEL_MREQ: read_val = mask_q[hit_cpu] & raw_q;
         default:  read_val = '1;
      endcase
   end

   for (genvar c = 0; c < NUM_CPUS; c++) begin : g_wen
      assign mask_wr_en[c] = bus_wr && hi_half && (hit_sel == SEL_MASK)
                             && (hit_cpu == CPU_W'(c));
   end
   assign mask_wr_val = {bus_wdata, latch_q};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         latch_q <= '0;
         rdata_q <= '0;
         err_q   <= 1'b0;
      end else begin
         err_q <= 1'b0;
         if (bus_wr) begin
            if (!hi_half)                 latch_q <= bus_wdata;
            else if (hit_sel == SEL_NONE) err_q   <= 1'b1;
         end else if (bus_rd) begin
            if (hi_half) begin
               rdata_q <= latch_q;
            end else if (hit_sel == SEL_NONE) begin
               rdata_q <= '1;
               err_q   <= 1'b1;
            end else begin
               rdata_q <= read_val[DATA_W-1:0];
               latch_q <= read_val[REG_W-1:DATA_W];
            end
         end
      end
   end

   assign bus_rdata = rdata_q;
   assign bus_err   = err_q;

   AST_LOW_WRITE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !hi_half) |=> (latch_q == $past(bus_wdata)) && !bus_err); // R6
   AST_ONE_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mask_wr_en)); // R6
   AST_HIGH_READ_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_wr && bus_rd && hi_half) |=> (bus_rdata == $past(latch_q)) && !bus_err); // R8
   AST_UNDEF_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_wr && bus_rd && !hi_half && hit_sel == SEL_NONE)
      |=> bus_err && (bus_rdata == '1) && $stable(latch_q)); // R9
   AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_wr && !bus_rd) |=> !bus_err); // R9

endmodule

// File: rtl/irq_router_top.sv
module irq_router_top #(
   parameter int NUM_LINES   = 64,
   parameter int NUM_CPUS    = 4,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 12,
   parameter int CASCADE_BIT = 55,
   parameter int SYNC_STAGES = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] dev_irq,
   input  logic                 cascade_irq,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_wr,
   input  logic                 bus_rd,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   output logic                 bus_err,
   output logic [NUM_CPUS-1:0]  cpu_irq
);

   localparam int REG_W = 2 * DATA_W;

   if (NUM_CPUS < 1 || NUM_CPUS > int'(irq_router_pkg::MAX_CPUS)) begin : g_bad_cpus
      $error("NUM_CPUS must lie in 1..4");
   end
   if (NUM_LINES < 1 || NUM_LINES > REG_W) begin : g_bad_lines
      $error("NUM_LINES must fit in one register");
   end

   logic [REG_W-1:0]               raw_q;
   logic [NUM_CPUS-1:0][REG_W-1:0] mask_q;
   logic [NUM_CPUS-1:0]            mask_wr_en;
   logic [REG_W-1:0]               mask_wr_val;

   irq_raw_capture #(
      .NUM_LINES  (NUM_LINES),
      .REG_W      (REG_W),
      .CASCADE_BIT(CASCADE_BIT),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_raw (
      .clk        (clk),
      .rst_n      (rst_n),
      .dev_irq    (dev_irq),
      .cascade_irq(cascade_irq),
      .raw_q      (raw_q)
   );

   irq_mask_bank #(
      .NUM_CPUS(NUM_CPUS),
      .REG_W   (REG_W)
   ) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (mask_wr_en),
      .wr_val (mask_wr_val),
      .raw_q  (raw_q),
      .mask_q (mask_q),
      .cpu_irq(cpu_irq)
   );

   irq_csr_port #(
      .NUM_CPUS(NUM_CPUS),
      .DATA_W  (DATA_W),
      .REG_W   (REG_W),
      .ADDR_W  (ADDR_W)
   ) u_csr (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_wr     (bus_wr),
      .bus_rd     (bus_rd),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .bus_err    (bus_err),
      .raw_q      (raw_q),
      .mask_q     (mask_q),
      .mask_wr_en (mask_wr_en),
      .mask_wr_val(mask_wr_val)
   );

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> (cpu_irq == '0) && !bus_err && (bus_rdata == '0)); // R1

endmodule

// File: tb/sim_irq_router_top.sv
`timescale 1ns/1ps
module sim_irq_router_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] dev_irq = '0;
   logic        cascade_irq = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_err;
   logic [3:0]  cpu_irq;

   int checks = 0;
   int errors = 0;
   bit model_live = 1'b0;

   always #5 clk = ~clk;

   irq_router_top u0 (
      .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .cascade_irq(cascade_irq),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
      .cpu_irq(cpu_irq)
   );

   // ---------------- behavioural reference model ----------------
   logic [63:0] m_raw;
   logic [63:0] m_mask [4];
   logic [31:0] m_latch;
   logic [31:0] m_rdata;
   logic        m_err;

   // kind: 0 none, 1 mask, 2 masked request, 3 raw
   function automatic void lookup(input logic [11:0] a, output int kind, output int idx);
      kind = 0; idx = 0;
      case (a & 12'hFFB)
         12'h200: begin kind = 1; idx = 0; end
         12'h240: begin kind = 1; idx = 1; end
         12'h600: begin kind = 1; idx = 2; end
         12'h640: begin kind = 1; idx = 3; end
         12'h280: begin kind = 2; idx = 0; end
         12'h2C0: begin kind = 2; idx = 1; end
         12'h680: begin kind = 2; idx = 2; end
         12'h6C0: begin kind = 2; idx = 3; end
         12'h300: kind = 3;
         default: kind = 0;
      endcase
   endfunction

   function automatic logic [3:0] model_irq();
      logic [3:0] r;
      for (int c = 0; c < 4; c++) r[c] = (m_mask[c] & m_raw) != 0;
      return r;
   endfunction

   always @(posedge clk) begin
      int kind, idx;
      logic [63:0] v, next_raw;
      if (!rst_n) begin
         m_raw = '0; m_latch = '0; m_rdata = '0; m_err = 1'b0;
         for (int c = 0; c < 4; c++) m_mask[c] = '0;
      end else begin
         next_raw = dev_irq;
         next_raw[55] = dev_irq[55] | cascade_irq;
         m_err = 1'b0;
         lookup(bus_addr, kind, idx);
         if (bus_wr) begin
            if (!bus_addr[2]) m_latch = bus_wdata;
            else if (kind == 0) m_err = 1'b1;
            else if (kind == 1) m_mask[idx] = {bus_wdata, m_latch};
         end else if (bus_rd) begin
            if (bus_addr[2]) m_rdata = m_latch;
            else if (kind == 0) begin m_rdata = 32'hFFFF_FFFF; m_err = 1'b1; end
            else begin
               if (kind == 1) v = m_mask[idx];
               else if (kind == 2) v = m_mask[idx] & m_raw;
               else v = m_raw;
               m_rdata = v[31:0];
               m_latch = v[63:32];
            end
         end
         m_raw = next_raw;
      end
      model_live = 1'b1;
   end

   always @(negedge clk) begin
      if (model_live) begin
         checks += 3;
         if (cpu_irq !== model_irq()) begin
            errors++;
            $display("FAIL R5 cycle compare cpu_irq act=%b exp=%b", cpu_irq, model_irq());
         end
         if (bus_rdata !== m_rdata) begin
            errors++;
            $display("FAIL R8 cycle compare rdata act=%h exp=%h", bus_rdata, m_rdata);
         end
         if (bus_err !== m_err) begin
            errors++;
            $display("FAIL R9 cycle compare err act=%b exp=%b", bus_err, m_err);
         end
      end
   end

   // ---------------- directed helpers ----------------
   task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wr32(input logic [11:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd32(input logic [11:0] a, output logic [31:0] d, output logic e);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata; e = bus_err;
   endtask

   task automatic rd64(input logic [11:0] a, output logic [63:0] d);
      logic [31:0] lo, hi;
      logic e;
      rd32(a, lo, e);
      rd32(a | 12'h004, hi, e);
      d = {hi, lo};
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : stim
      logic [63:0] v;
      logic [31:0] w;
      logic        e;
      repeat (3) @(negedge clk);
      check64("R1 cpu_irq after reset", 64'(cpu_irq), 64'h0);
      check64("R1 rdata after reset", 64'(bus_rdata), 64'h0);
      rst_n = 1'b1;
      tick();
      rd64(12'h300, v); check64("R1 raw zero", v, 64'h0);
      rd64(12'h640, v); check64("R1 mask3 zero", v, 64'h0);

      // R2: raw follows lines
      dev_irq = (64'h1 << 3) | (64'h1 << 40);
      tick();
      rd64(12'h300, v); check64("R2 raw capture", v, 64'h0000_0100_0000_0008);

      // R3: bit 55 from device line or cascade
      dev_irq[55] = 1'b1; tick();
      rd64(12'h300, v); check64("R3 line 55", v, 64'h0080_0100_0000_0008);
      dev_irq[55] = 1'b0; cascade_irq = 1'b1; tick();
      rd64(12'h300, v); check64("R3 cascade", v, 64'h0080_0100_0000_0008);
      cascade_irq = 1'b0; tick();

      // R6: split write to mask0
      wr32(12'h200, 32'h0000_0008);
      check64("R6 low half no commit", 64'(cpu_irq), 64'h0);
      wr32(12'h204, 32'h0000_0100);
      check64("R5 irq0 raised", 64'(cpu_irq), 64'h1);
      rd64(12'h200, v); check64("R6 mask0 value", v, 64'h0000_0100_0000_0008);
      rd64(12'h280, v); check64("R4 masked0", v, 64'h0000_0100_0000_0008);
      dev_irq[3] = 1'b0; tick();
      rd64(12'h280, v); check64("R4 masked0 partial", v, 64'h0000_0100_0000_0000);
      check64("R5 irq0 still high", 64'(cpu_irq), 64'h1);
      dev_irq[40] = 1'b0; tick();
      check64("R5 irq0 dropped", 64'(cpu_irq), 64'h0);

      // CPU2 mask on bit 55
      wr32(12'h600, 32'h0);
      wr32(12'h604, 32'h0080_0000);
      check64("R5 irq2 idle", 64'(cpu_irq), 64'h0);
      cascade_irq = 1'b1; tick();
      check64("R5 irq2 via cascade", 64'(cpu_irq), 64'h4);
      rd64(12'h680, v); check64("R4 masked2", v, 64'h0080_0000_0000_0000);
      cascade_irq = 1'b0; tick();

      // R7: read-only offsets ignore writes
      wr32(12'h300, 32'hFFFF_FFFF); wr32(12'h304, 32'hFFFF_FFFF);
      rd64(12'h300, v); check64("R7 raw unchanged", v, 64'h0);
      wr32(12'h680, 32'hFFFF_FFFF); wr32(12'h684, 32'hFFFF_FFFF);
      rd64(12'h600, v); check64("R7 mask2 unchanged", v, 64'h0080_0000_0000_0000);

      // R9: undefined offset
      rd32(12'h100, w, e);
      check64("R9 undefined read ones", 64'(w), 64'hFFFF_FFFF);
      check64("R9 undefined read err", 64'(e), 64'h1);
      rd32(12'h104, w, e);
      check64("R9 latch kept", 64'(w), 64'h0080_0000);
      check64("R9 high read no err", 64'(e), 64'h0);

      // R10: shared latch
      rd32(12'h300, w, e);
      wr32(12'h240, 32'h1234_5678);
      rd32(12'h244, w, e);
      check64("R10 latch replaced", 64'(w), 64'h1234_5678);
      rd64(12'h240, v); check64("R10 mask1 untouched", v, 64'h0);

      // R6: write wins over simultaneous read
      wr32(12'h240, 32'h0000_0005);
      bus_addr = 12'h244; bus_wdata = 32'h0000_000A; bus_wr = 1'b1; bus_rd = 1'b1;
      tick();
      bus_wr = 1'b0; bus_rd = 1'b0;
      rd64(12'h240, v); check64("R6 write beats read", v, 64'h0000_000A_0000_0005);

      // random collisions of line changes and accesses
      for (int n = 0; n < 600; n++) begin
         logic [11:0] pick [18] = '{12'h200, 12'h204, 12'h240, 12'h244, 12'h280,
            12'h284, 12'h2C0, 12'h300, 12'h304, 12'h600, 12'h604, 12'h640,
            12'h644, 12'h680, 12'h6C0, 12'h6C4, 12'h100, 12'h104};
         if ($urandom_range(3) == 0) dev_irq = {$urandom(), $urandom()} & {$urandom(), $urandom()};
         cascade_irq = ($urandom_range(3) == 0);
         bus_addr  = pick[$urandom_range(17)];
         bus_wdata = $urandom();
         bus_wr    = ($urandom_range(2) == 0);
         bus_rd    = ($urandom_range(2) == 0);
         tick();
      end
      bus_wr = 1'b0; bus_rd = 1'b0;
      tick();

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule